// File: doc/BRIEF.md
# Translation and Exception Control Register File

This block is the bank of control registers that a processor core keeps next to its address translation unit. It holds the translation control word, the two halves of the current page-table entry and a small assist field, the translation table base pointer, the faulting address, the trap code, and the exception and interrupt event codes. Software reaches the bank through a word-indexed read/write port. Each register keeps only the bits that it defines. Two of the writes also act on the translation buffer. Setting the invalidate bit in the control word requests a full invalidation. Changing the address-space identifier in the entry-high register requests a flush.

The same decoder also serves a few neighbouring registers. A refresh counter steps forward each time it is read. An I/O interrupt control register accepts only the value zero. A clock-ratio register always reads as zero. The wait-state and memory-control slots are placeholders that drop writes and return zero.

Every result is registered. Read data, the error flag and the side-effect pulses appear in the cycle after the request is sampled, and each lasts one cycle. The translation buffer itself sits outside this block. It consumes the two pulses.

Top module: `xlat_ctrl_regs`

## Requirements
- R1: A write to index 0 (translation control, 32-bit access) stores the value with bit 2 forced to 0. When bit 2 of the written value is 1, `tlb_inval_pulse` is high for the one cycle after the write.
- R2: A write to index 1 (entry high, 32-bit access) stores all 32 bits. `tlb_flush_pulse` is high for one cycle when bits [7:0] of the new value differ from the stored bits [7:0], and stays low when they are equal.
- R3: Indices 6, 7 and 8 (trap code, exception event, interrupt event, 32-bit access) keep bits [10:0] of a written value and read bits [31:11] as 0.
- R4: Index 3 (entry assist) keeps bits [3:0] only. Indices 2, 4 and 5 (entry low, table base, faulting address) keep all 32 bits. All of these use 32-bit access.
- R5: Index 9 (refresh counter, 16-bit access) returns its current value on a read and then increments by one, wrapping from 0xFFFF to 0. A write loads it directly.
- R6: Index 10 (I/O interrupt control, 16-bit access) accepts a zero write with no flag. A nonzero write is dropped and raises `unsup_pulse` for one cycle. A read returns 0.
- R7: Index 11 (clock ratio, 16-bit access) reads 0. Indices 12 and 13 (wait and memory control, 32-bit access) drop writes and read 0.
- R8: The size codes are 1 for 16-bit and 2 for 32-bit. An access to indices 14 or 15, or with a size code other than the one the index requires, raises `bus_err` for one cycle. Such an access changes no register, raises no other pulse, and a read returns 0.
- R9: After reset every register reads 0. `bus_rdata`, `bus_rvalid`, `bus_err` and the three pulses are registered. They reflect the request sampled at the previous clock edge, and a read in the cycle directly after a write sees the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register word index |
| bus_size | input | 2 | Access size code (1 = 16-bit, 2 = 32-bit) |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read response valid |
| bus_err | output | 1 | Undecoded index or wrong size |
| unsup_pulse | output | 1 | Nonzero I/O interrupt control write rejected |
| tlb_inval_pulse | output | 1 | Full translation-buffer invalidate request |
| tlb_flush_pulse | output | 1 | Flush request on address-space change |

## Verification
Two kinds of event can land close together. The first is a read of the refresh counter: it has to return the old value while the same edge commits the increment, and the bench provokes this with reads back to back across the wrap point. The second is a pair of side-effect writes on consecutive cycles: an invalidating control write followed at once by an ASID-changing entry write, which must show up as two separate single-cycle pulses on different outputs. A behavioural reference model judges every cycle. It compares the read data, the error flag and the pulses, and also covers wrong-width accesses that must not leave a pulse or a stored value behind.

// File: rtl/xlat_regs_pkg.sv
package xlat_regs_pkg;

   // register word indices; each index is fixed by the software-visible map
   typedef enum logic [3:0] {
      RG_MMUCTL  = 4'd0,
      RG_PTEHI   = 4'd1,
      RG_PTELO   = 4'd2,
      RG_PTEAS   = 4'd3,
      RG_TBASE   = 4'd4,
      RG_EXCADR  = 4'd5,
      RG_TRAP    = 4'd6,
      RG_EXCEVT  = 4'd7,
      RG_INTEVT  = 4'd8,
      RG_REFRESH = 4'd9,
      RG_GPIOIC  = 4'd10,
      RG_FREQ    = 4'd11,
      RG_WAITC   = 4'd12,
      RG_MEMC    = 4'd13,
      RG_NONE    = 4'd15
   } reg_id_e;

   localparam int          IDX_W      = 4;
   localparam int          NUM_STORED = 9;      // indices 0..8 hold plain storage
   localparam logic [3:0]  LAST_DEC   = 4'd13;

   localparam logic [1:0]  SZ_HALF = 2'd1;
   localparam logic [1:0]  SZ_WORD = 2'd2;

endpackage

// File: rtl/xlat_decode.sv
module xlat_decode
   import xlat_regs_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output reg_id_e           id,
   output logic              hit
);

   logic upper_zero;
   logic [1:0] need;

   generate
      if (ADDR_W > IDX_W) begin : g_wide
         assign upper_zero = (addr[ADDR_W-1:IDX_W] == '0);
      end else begin : g_exact
         assign upper_zero = 1'b1;
      end
   endgenerate

   always_comb begin
      id = RG_NONE;
      if (upper_zero && (addr[IDX_W-1:0] <= LAST_DEC))
         id = reg_id_e'(addr[IDX_W-1:0]);
      need = ((id == RG_REFRESH) || (id == RG_GPIOIC) || (id == RG_FREQ)) ? SZ_HALF : SZ_WORD;
      hit  = (id != RG_NONE) && (size == need);
   end

endmodule

// File: rtl/xlat_mreg.sv
module xlat_mreg #(
   parameter int           W    = 32,
   parameter logic [W-1:0] KEEP = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d & KEEP;
   end

endmodule

// File: rtl/xlat_refresh.sv
module xlat_refresh #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   input  logic         inc,
   output logic [W-1:0] q
);

   always_ff @(posedge clk) begin
      if (!rst_n)   q <= '0;
      else if (ld)  q <= ld_val;
      else if (inc) q <= q + W'(1);
   end

endmodule

// File: rtl/xlat_ctrl_regs.sv
module xlat_ctrl_regs
   import xlat_regs_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int ASID_W    = 8,
   parameter int EVT_W     = 11,
   parameter int ASSIST_W  = 4,
   parameter int HALF_W    = 16,
   parameter int REFRESH_W = 16,
   parameter int INVAL_BIT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [1:0]        bus_size,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              bus_rvalid,
   output logic              bus_err,
   output logic              unsup_pulse,
   output logic              tlb_inval_pulse,
   output logic              tlb_flush_pulse
);

   localparam logic [DATA_W-1:0] ALL_KEEP    = '1;
   localparam logic [DATA_W-1:0] EVT_KEEP    = {{(DATA_W-EVT_W){1'b0}}, {EVT_W{1'b1}}};
   localparam logic [DATA_W-1:0] ASSIST_KEEP = {{(DATA_W-ASSIST_W){1'b0}}, {ASSIST_W{1'b1}}};
   localparam logic [DATA_W-1:0] INVAL_KEEP  = ~(DATA_W'(1) << INVAL_BIT);

   generate
      if (ADDR_W < IDX_W)          begin : g_bad_addr  $error("ADDR_W too small for the map"); end
      if (ASID_W > DATA_W)         begin : g_bad_asid  $error("ASID_W exceeds DATA_W"); end
      if (EVT_W >= DATA_W)         begin : g_bad_evt   $error("EVT_W must be below DATA_W"); end
      if (ASSIST_W >= DATA_W)      begin : g_bad_as    $error("ASSIST_W must be below DATA_W"); end
      if (INVAL_BIT >= DATA_W)     begin : g_bad_inv   $error("INVAL_BIT outside the word"); end
      if (HALF_W > DATA_W)         begin : g_bad_half  $error("HALF_W exceeds DATA_W"); end
      if (REFRESH_W > HALF_W)      begin : g_bad_ref   $error("REFRESH_W exceeds HALF_W"); end
   endgenerate

   reg_id_e     id;
   logic [3:0]  id_n;
   logic        hit, wr_ok, rd_ok;
   logic [DATA_W-1:0]    store_q [NUM_STORED];
   logic [REFRESH_W-1:0] ref_q;
   logic [DATA_W-1:0]    rd_mux;

   xlat_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .size (bus_size),
      .id   (id),
      .hit  (hit)
   );

   assign id_n  = id;
   assign wr_ok = bus_req &&  bus_wr && hit;
   assign rd_ok = bus_req && !bus_wr && hit;

   for (genvar g = 0; g < NUM_STORED; g++) begin : g_store
      localparam logic [DATA_W-1:0] KEEP =
         (g == int'(RG_MMUCTL))                          ? INVAL_KEEP  :
         (g == int'(RG_PTEAS))                           ? ASSIST_KEEP :
         (g >= int'(RG_TRAP) && g <= int'(RG_INTEVT))    ? EVT_KEEP    : ALL_KEEP;
      xlat_mreg #(.W(DATA_W), .KEEP(KEEP)) u_reg (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (wr_ok && (id_n == 4'(g))),
         .d     (bus_wdata),
         .q     (store_q[g])
      );
   end

   xlat_refresh #(.W(REFRESH_W)) u_refresh (
      .clk    (clk),
      .rst_n  (rst_n),
      .ld     (wr_ok && (id == RG_REFRESH)),
      .ld_val (bus_wdata[REFRESH_W-1:0]),
      .inc    (rd_ok && (id == RG_REFRESH)),
      .q      (ref_q)
   );

   // GPIOIC, FREQ, WAITC and MEMC hold nothing and fall through to zero
   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_STORED; i++)
         if (id_n == 4'(i)) rd_mux = store_q[i];
      if (id == RG_REFRESH) rd_mux = DATA_W'(ref_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bus_rdata       <= '0;
         bus_rvalid      <= 1'b0;
         bus_err         <= 1'b0;
         unsup_pulse     <= 1'b0;
         tlb_inval_pulse <= 1'b0;
         tlb_flush_pulse <= 1'b0;
      end else begin
         bus_rdata       <= rd_ok ? rd_mux : '0;
         bus_rvalid      <= bus_req && !bus_wr;
         bus_err         <= bus_req && !hit;
         unsup_pulse     <= wr_ok && (id == RG_GPIOIC) && (bus_wdata[HALF_W-1:0] != '0);
         tlb_inval_pulse <= wr_ok && (id == RG_MMUCTL) && bus_wdata[INVAL_BIT];
         tlb_flush_pulse <= wr_ok && (id == RG_PTEHI) &&
                            (bus_wdata[ASID_W-1:0] != store_q[int'(RG_PTEHI)][ASID_W-1:0]);
      end
   end

endmodule

// File: rtl/xlat_ctrl_regs_chk.sv
module xlat_ctrl_regs_chk #(
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 4,
   parameter int EVT_W     = 11,
   parameter int HALF_W    = 16,
   parameter int INVAL_BIT = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_req,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [1:0]        bus_size,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic              bus_rvalid,
   input logic              bus_err,
   input logic              unsup_pulse,
   input logic              tlb_inval_pulse,
   input logic              tlb_flush_pulse
);

   AST_INVAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_inval_pulse |-> $past(bus_req && bus_wr && bus_addr == ADDR_W'(0) &&
                                bus_size == 2'd2 && bus_wdata[INVAL_BIT])); // R1

   AST_INVAL_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rvalid && $past(bus_addr == ADDR_W'(0))) |-> !bus_rdata[INVAL_BIT]); // R1

   AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_flush_pulse |-> $past(bus_req && bus_wr && bus_addr == ADDR_W'(1) &&
                                bus_size == 2'd2)); // R2

   AST_EVT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rvalid && $past(bus_addr >= ADDR_W'(6) && bus_addr <= ADDR_W'(8)))
      |-> (bus_rdata[DATA_W-1:EVT_W] == '0)); // R3

   AST_UNSUP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      unsup_pulse |-> $past(bus_req && bus_wr && bus_addr == ADDR_W'(10) &&
                            bus_wdata[HALF_W-1:0] != '0)); // R6

   AST_ERR_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && bus_rvalid) |-> (bus_rdata == '0)); // R8

   AST_ERR_NO_SIDE_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> !(tlb_inval_pulse || tlb_flush_pulse || unsup_pulse)); // R8

   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tlb_inval_pulse, tlb_flush_pulse, unsup_pulse})); // R9

   AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bus_req) |-> !(bus_rvalid || bus_err)); // R9

endmodule

bind xlat_ctrl_regs xlat_ctrl_regs_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .EVT_W(EVT_W), .HALF_W(HALF_W), .INVAL_BIT(INVAL_BIT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
   .bus_rvalid(bus_rvalid), .bus_err(bus_err), .unsup_pulse(unsup_pulse),
   .tlb_inval_pulse(tlb_inval_pulse), .tlb_flush_pulse(tlb_flush_pulse)
);

// File: tb/test_xlat_ctrl_regs.sv
`timescale 1ns/1ps
module test_xlat_ctrl_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [1:0]  bus_size = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_rvalid, bus_err, unsup_pulse, tlb_inval_pulse, tlb_flush_pulse;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;
   string cur_tag = "R9";

   always #4 clk = ~clk;   // 125 MHz

   xlat_ctrl_regs i_xlat_ctrl_regs (
      .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_rvalid(bus_rvalid), .bus_err(bus_err), .unsup_pulse(unsup_pulse),
      .tlb_inval_pulse(tlb_inval_pulse), .tlb_flush_pulse(tlb_flush_pulse)
   );

   // behavioural reference model
   logic [31:0] m_reg [0:8];
   logic [15:0] m_ref;
   logic [31:0] e_rdata;
   logic        e_rvalid, e_err, e_uns, e_inv, e_fl;
   string       e_tag = "R9";

   always @(posedge clk) begin
      e_rdata = '0; e_rvalid = 0; e_err = 0; e_uns = 0; e_inv = 0; e_fl = 0;
      e_tag = cur_tag;
      if (!rst_n) begin
         for (int i = 0; i <= 8; i++) m_reg[i] = '0;
         m_ref = '0;
      end else if (bus_req) begin
         int  a;
         bit  half, ok;
         a    = int'(bus_addr);
         half = (a == 9 || a == 10 || a == 11);
         ok   = (a <= 13) && (bus_size == (half ? 2'd1 : 2'd2));
         e_err    = !ok;
         e_rvalid = !bus_wr;
         if (ok && bus_wr) begin
            case (a)
               0: begin m_reg[0] = bus_wdata & ~32'h4; e_inv = bus_wdata[2]; end
               1: begin e_fl = (bus_wdata[7:0] != m_reg[1][7:0]); m_reg[1] = bus_wdata; end
               2, 4, 5: m_reg[a] = bus_wdata;
               3: m_reg[3] = bus_wdata & 32'hF;
               6, 7, 8: m_reg[a] = bus_wdata & 32'h7FF;
               9: m_ref = bus_wdata[15:0];
               10: e_uns = (bus_wdata[15:0] != 16'h0);
               default: ;
            endcase
         end else if (ok) begin
            if (a <= 8) e_rdata = m_reg[a];
            else if (a == 9) begin e_rdata = {16'h0, m_ref}; m_ref = m_ref + 16'd1; end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         n_checks++;
         if (bus_rdata !== e_rdata || bus_rvalid !== e_rvalid || bus_err !== e_err ||
             unsup_pulse !== e_uns || tlb_inval_pulse !== e_inv || tlb_flush_pulse !== e_fl) begin
            n_fail++;
            $display("FAIL %s t=%0t actual rd=%h rv=%b err=%b uns=%b inv=%b fl=%b expected rd=%h rv=%b err=%b uns=%b inv=%b fl=%b",
                     e_tag, $time, bus_rdata, bus_rvalid, bus_err, unsup_pulse, tlb_inval_pulse,
                     tlb_flush_pulse, e_rdata, e_rvalid, e_err, e_uns, e_inv, e_fl);
         end
      end
   end

   task automatic acc(input string tag, input bit wr, input int a, input logic [1:0] sz,
                      input logic [31:0] wd);
      cur_tag   = tag;
      bus_req   = 1'b1;
      bus_wr    = wr;
      bus_addr  = 4'(a);
      bus_size  = sz;
      bus_wdata = wd;
      @(negedge clk);
      bus_req   = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: reset state of every index, each at its proper size
      for (int a = 0; a < 16; a++)
         acc("R9", 0, a, (a >= 9 && a <= 11) ? 2'd1 : 2'd2, 32'h0);
      // R1: invalidate bit never stored, pulse only when set
      acc("R1", 1, 0, 2'd2, 32'hFFFF_FFFF);
      acc("R1", 0, 0, 2'd2, 0);
      acc("R1", 1, 0, 2'd2, 32'h0000_0004);
      acc("R1", 1, 0, 2'd2, 32'h0000_0000);
      acc("R1", 0, 0, 2'd2, 0);
      // R2: flush on ASID change only
      acc("R2", 1, 1, 2'd2, 32'h1234_5678);
      acc("R2", 1, 1, 2'd2, 32'hABCD_0078);
      acc("R2", 1, 1, 2'd2, 32'hABCD_0079);
      acc("R2", 0, 1, 2'd2, 0);
      // R1/R2 back to back: invalidate then ASID change on consecutive cycles
      acc("R1", 1, 0, 2'd2, 32'h0000_0005);
      acc("R2", 1, 1, 2'd2, 32'h0000_00AA);
      idle(2);
      // R3: event code masks
      for (int a = 6; a <= 8; a++) acc("R3", 1, a, 2'd2, 32'hFFFF_FFFF);
      for (int a = 6; a <= 8; a++) acc("R3", 0, a, 2'd2, 0);
      // R4: assist mask and full-width registers
      acc("R4", 1, 3, 2'd2, 32'hFFFF_FFFF);
      acc("R4", 1, 2, 2'd2, 32'hDEAD_BEEF);
      acc("R4", 1, 4, 2'd2, 32'h8000_0001);
      acc("R4", 1, 5, 2'd2, 32'h5A5A_A5A5);
      for (int a = 2; a <= 5; a++) acc("R4", 0, a, 2'd2, 0);
      // R5: post-increment across the wrap, then direct load
      acc("R5", 1, 9, 2'd1, 32'h0000_FFFE);
      for (int k = 0; k < 4; k++) acc("R5", 0, 9, 2'd1, 0);
      acc("R5", 1, 9, 2'd1, 32'h0000_1234);
      idle(1);
      acc("R5", 0, 9, 2'd1, 0);
      // R6: zero accepted, nonzero flagged
      acc("R6", 1, 10, 2'd1, 32'h0);
      acc("R6", 1, 10, 2'd1, 32'h0000_0005);
      acc("R6", 0, 10, 2'd1, 0);
      // R7: constant-zero and ignored registers
      acc("R7", 1, 11, 2'd1, 32'hFFFF_FFFF);
      acc("R7", 0, 11, 2'd1, 0);
      acc("R7", 1, 12, 2'd2, 32'hFFFF_FFFF);
      acc("R7", 1, 13, 2'd2, 32'hFFFF_FFFF);
      acc("R7", 0, 12, 2'd2, 0);
      acc("R7", 0, 13, 2'd2, 0);
      // R8: wrong width and undecoded indices leave no trace
      acc("R8", 1, 0, 2'd1, 32'h0000_0004);
      acc("R8", 0, 0, 2'd2, 0);
      acc("R8", 1, 1, 2'd1, 32'h0000_0011);
      acc("R8", 0, 1, 2'd2, 0);
      acc("R8", 0, 9, 2'd2, 0);
      acc("R8", 0, 9, 2'd1, 0);
      acc("R8", 1, 10, 2'd2, 32'h0000_0007);
      acc("R8", 0, 14, 2'd2, 0);
      acc("R8", 1, 15, 2'd2, 32'hFFFF_FFFF);
      acc("R8", 0, 3, 2'd0, 0);
      acc("R8", 1, 6, 2'd0, 32'h0000_0123);
      acc("R8", 0, 6, 2'd2, 0);
      idle(3);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R9 watchdog actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule